// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block predicts the next fetch address of an RV32 pipeline. It keeps a direct-mapped table. Each slot holds a valid bit, the complete address of a branch instruction, the address that branch last jumped to, and a two-bit saturating confidence counter. The fetch address is looked up combinationally in the same cycle it is presented. When the stored address matches and the counter leans taken, the block drives a redirect target straight to the program counter. A correctly predicted taken branch therefore costs no bubble.

A branch unit later in the pipeline reports each resolved control transfer through an update port. The report carries the branch address, its real target, whether it was taken, and whether the earlier guess was wrong. The table learns from these reports: counters step up or down and saturate at both ends, targets are refreshed, and new slots are claimed.

A build-time parameter turns the block into a lighter decode-stage hint unit. In that mode the table keeps only valid bits and counters, and it has no address tag. Jumps-and-link are always guessed taken. A conditional branch with no history is guessed taken when its offset points backward; once it has history, its counter decides.

Top module: `fetch_target_predictor`

## Requirements
- R1: After reset every slot is empty. No fetch address produces a prediction, and `fetch_pred_target` reads zero whenever `fetch_pred_valid` is low.
- R2: The slot is selected by address bits [TBL_LOG2+1:2]. A prediction needs a valid slot whose stored address equals the whole fetch address. Another address that maps to the same slot gets no prediction.
- R3: In target-buffer mode the prediction is combinational in the fetch cycle. It is given when the counter is 2 or 3 (0 strongly not-taken, 1 weakly not-taken, 2 weakly taken, 3 strongly taken), and its target is the stored target.
- R4: A report that misses the table claims the slot only when both taken and mispredict are 1. The slot gets the branch address, the reported target and counter value 2, and it predicts from the next cycle on. A miss that is not taken, or that is taken with mispredict 0, leaves the table unchanged.
- R5: A report that hits moves the counter up by one when taken and down by one when not taken, whatever the mispredict flag. The counter stops at 3 and at 0.
- R6: A taken report that hits overwrites the stored target with the reported target. A not-taken hit keeps the old target.
- R7: When a report and a fetch lookup address the same slot in the same cycle, the lookup sees the slot's contents from before the report. The effect of the report is visible from the following cycle.
- R8: In counter-table mode (USE_TB = 0), `fetch_pred_valid` stays 0. A valid decode instruction with opcode 1101111 (jump-and-link) is predicted taken, with target equal to the decode PC plus its sign-extended J-type immediate.
- R9: In counter-table mode, a conditional branch (opcode 1100011) whose slot is empty is predicted taken exactly when instruction bit 31 is 1 (backward offset). Its target is the PC plus the B-type immediate. Any other opcode is never predicted, and `dec_pred_target` is zero when not taken.
- R10: In counter-table mode, slots carry no tag. A report claims an empty slot with counter 2 when taken and 1 when not taken, ignoring mispredict. Afterwards the slot's counter (taken when 2 or 3) replaces the backward-offset rule for every branch that maps to it.
- R11: In target-buffer mode `dec_pred_taken` stays 0, even for jump-and-link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| fetch_pred_valid | output | 1 | Redirect fetch to `fetch_pred_target` |
| fetch_pred_target | output | ADDR_W | Predicted next fetch address, zero when not valid |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_pc | input | ADDR_W | Address of the decode instruction |
| dec_instr | input | 32 | Decode instruction word |
| dec_pred_taken | output | 1 | Decode-time taken guess (counter-table mode) |
| dec_pred_target | output | ADDR_W | Decode-time target, zero when not taken |
| upd_valid | input | 1 | A resolved branch report is present |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_target | input | ADDR_W | Actual target of the resolved branch |
| upd_taken | input | 1 | Branch was taken |
| upd_mispredict | input | 1 | Earlier prediction was wrong |

## Verification
The one overlap that matters is a table update and a fetch lookup hitting the same slot in one cycle. The bench provokes it twice. First it retires a not-taken report for the very address being fetched while that slot still leans taken. Then it claims a fresh slot for an address fetched in that same cycle. Each time it samples the prediction just after the falling edge of the shared cycle and expects the old contents. It samples again one cycle later and expects the updated contents.

// File: rtl/btb_pkg.sv
package btb_pkg;

  localparam logic [1:0] CTR_STRONG_NT = 2'd0;
  localparam logic [1:0] CTR_WEAK_NT   = 2'd1;
  localparam logic [1:0] CTR_WEAK_T    = 2'd2;
  localparam logic [1:0] CTR_STRONG_T  = 2'd3;

  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;

  function automatic logic [1:0] ctr_up(input logic [1:0] c);
    return (c == CTR_STRONG_T) ? CTR_STRONG_T : c + 2'd1;
  endfunction

  function automatic logic [1:0] ctr_dn(input logic [1:0] c);
    return (c == CTR_STRONG_NT) ? CTR_STRONG_NT : c - 2'd1;
  endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rda_idx,
  output logic          rda_valid,
  output logic [1:0]    rda_ctr,
  output logic [AW-1:0] rda_tag,
  output logic [AW-1:0] rda_tgt,
  input  logic [IW-1:0] rdb_idx,
  output logic          rdb_valid,
  output logic [1:0]    rdb_ctr,
  output logic [AW-1:0] rdb_tag,
  input  logic [IW-1:0] wr_idx,
  input  logic          ctr_we,
  input  logic [1:0]    ctr_wdata,
  input  logic          tag_we,
  input  logic [AW-1:0] tag_wdata,
  input  logic          tgt_we,
  input  logic [AW-1:0] tgt_wdata
);

  localparam int DEPTH = 1 << IW;

  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] valid_d;
  logic [1:0]       ctr_q [DEPTH];
  logic [AW-1:0]    tag_q [DEPTH];
  logic [AW-1:0]    tgt_q [DEPTH];

  // per-slot valid flops with async clear
  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_comb begin
      valid_d[e] = valid_q[e] | (ctr_we && (wr_idx == IW'(e)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q[e] <= 1'b0;
      else        valid_q[e] <= valid_d[e];
    end
  end

  // data arrays: clock-enabled, not reset
  always_ff @(posedge clk) begin
    if (ctr_we) ctr_q[wr_idx] <= ctr_wdata;
  end

  always_ff @(posedge clk) begin
    if (tag_we) tag_q[wr_idx] <= tag_wdata;
  end

  always_ff @(posedge clk) begin
    if (tgt_we) tgt_q[wr_idx] <= tgt_wdata;
  end

  assign rda_valid = valid_q[rda_idx];
  assign rda_ctr   = ctr_q[rda_idx];
  assign rda_tag   = tag_q[rda_idx];
  assign rda_tgt   = tgt_q[rda_idx];
  assign rdb_valid = valid_q[rdb_idx];
  assign rdb_ctr   = ctr_q[rdb_idx];
  assign rdb_tag   = tag_q[rdb_idx];

  // counter on a live slot moves by at most one step and never wraps
  assert_ctr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_we && valid_q[wr_idx] && !tag_we) |=>
      (({1'b0, ctr_q[$past(wr_idx)]} == {1'b0, $past(ctr_q[wr_idx])} + 3'd1) ||
       ({1'b0, ctr_q[$past(wr_idx)]} + 3'd1 == {1'b0, $past(ctr_q[wr_idx])}) ||
       (ctr_q[$past(wr_idx)] == $past(ctr_q[wr_idx]))));

  // a freshly claimed slot is live and weakly taken
  assert_alloc_weak_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |=> (valid_q[$past(wr_idx)] && (ctr_q[$past(wr_idx)] == CTR_WEAK_T)));

endmodule

// File: rtl/btb_update_ctl.sv
module btb_update_ctl
  import btb_pkg::*;
#(
  parameter int AW     = 32,
  parameter bit TAG_EN = 1'b1
) (
  input  logic          upd_go,
  input  logic [AW-1:0] upd_pc,
  input  logic          upd_taken,
  input  logic          upd_mispredict,
  input  logic          rd_valid,
  input  logic [1:0]    rd_ctr,
  input  logic [AW-1:0] rd_tag,
  output logic          ctr_we,
  output logic [1:0]    ctr_wdata,
  output logic          tag_we,
  output logic          tgt_we
);

  logic slot_hit;

  assign slot_hit = rd_valid && (!TAG_EN || (rd_tag == upd_pc));

  always_comb begin
    ctr_we    = 1'b0;
    ctr_wdata = rd_ctr;
    tag_we    = 1'b0;
    tgt_we    = 1'b0;
    if (upd_go) begin
      if (slot_hit) begin
        ctr_we    = 1'b1;
        ctr_wdata = upd_taken ? ctr_up(rd_ctr) : ctr_dn(rd_ctr);
        tgt_we    = TAG_EN && upd_taken;
      end else if (TAG_EN) begin
        if (upd_taken && upd_mispredict) begin
          ctr_we    = 1'b1;
          ctr_wdata = CTR_WEAK_T;
          tag_we    = 1'b1;
          tgt_we    = 1'b1;
        end
      end else begin
        ctr_we    = 1'b1;
        ctr_wdata = upd_taken ? CTR_WEAK_T : CTR_WEAK_NT;
      end
    end
  end

endmodule

// File: rtl/btb_static_dec.sv
module btb_static_dec
  import btb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [31:0]   instr,
  input  logic [AW-1:0] pc,
  output logic          is_jal,
  output logic          is_branch,
  output logic          backward,
  output logic [AW-1:0] target
);

  logic [AW-1:0] j_off;
  logic [AW-1:0] b_off;

  assign is_jal    = (instr[6:0] == OPC_JAL);
  assign is_branch = (instr[6:0] == OPC_BRANCH);
  assign backward  = instr[31];

  assign j_off = {{(AW-20){instr[31]}}, instr[19:12], instr[20], instr[30:21], 1'b0};
  assign b_off = {{(AW-12){instr[31]}}, instr[7], instr[30:25], instr[11:8], 1'b0};

  assign target = pc + (is_jal ? j_off : b_off);

endmodule

// File: rtl/fetch_target_predictor.sv
module fetch_target_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int TBL_LOG2 = 4,
  parameter bit USE_TB   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              fetch_pred_valid,
  output logic [ADDR_W-1:0] fetch_pred_target,
  input  logic              dec_valid,
  input  logic [ADDR_W-1:0] dec_pc,
  input  logic [31:0]       dec_instr,
  output logic              dec_pred_taken,
  output logic [ADDR_W-1:0] dec_pred_target,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_taken,
  input  logic              upd_mispredict
);

  localparam int IDX_LO = 2;
  localparam int IDX_HI = TBL_LOG2 + IDX_LO - 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_ok_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ok_n = rst_pipe_q[1];

  logic [ADDR_W-1:0]   look_pc;
  logic [TBL_LOG2-1:0] look_idx;
  logic [TBL_LOG2-1:0] upd_idx;
  logic                upd_go;

  assign look_pc  = USE_TB ? fetch_pc : dec_pc;
  assign look_idx = look_pc[IDX_HI:IDX_LO];
  assign upd_idx  = upd_pc[IDX_HI:IDX_LO];
  assign upd_go   = upd_valid && rst_ok_n;

  logic              lk_valid;
  logic [1:0]        lk_ctr;
  logic [ADDR_W-1:0] lk_tag;
  logic [ADDR_W-1:0] lk_tgt;
  logic              up_valid;
  logic [1:0]        up_ctr;
  logic [ADDR_W-1:0] up_tag;
  logic              w_ctr_we;
  logic [1:0]        w_ctr;
  logic              w_tag_we;
  logic              w_tgt_we;

  btb_store #(.AW(ADDR_W), .IW(TBL_LOG2)) i_store (
    .clk       (clk),
    .rst_n     (rst_ok_n),
    .rda_idx   (look_idx),
    .rda_valid (lk_valid),
    .rda_ctr   (lk_ctr),
    .rda_tag   (lk_tag),
    .rda_tgt   (lk_tgt),
    .rdb_idx   (upd_idx),
    .rdb_valid (up_valid),
    .rdb_ctr   (up_ctr),
    .rdb_tag   (up_tag),
    .wr_idx    (upd_idx),
    .ctr_we    (w_ctr_we),
    .ctr_wdata (w_ctr),
    .tag_we    (w_tag_we),
    .tag_wdata (upd_pc),
    .tgt_we    (w_tgt_we),
    .tgt_wdata (upd_target)
  );

  btb_update_ctl #(.AW(ADDR_W), .TAG_EN(USE_TB)) i_upd (
    .upd_go         (upd_go),
    .upd_pc         (upd_pc),
    .upd_taken      (upd_taken),
    .upd_mispredict (upd_mispredict),
    .rd_valid       (up_valid),
    .rd_ctr         (up_ctr),
    .rd_tag         (up_tag),
    .ctr_we         (w_ctr_we),
    .ctr_wdata      (w_ctr),
    .tag_we         (w_tag_we),
    .tgt_we         (w_tgt_we)
  );

  logic              sd_jal;
  logic              sd_br;
  logic              sd_back;
  logic [ADDR_W-1:0] sd_target;

  btb_static_dec #(.AW(ADDR_W)) i_sdec (
    .instr     (dec_instr),
    .pc        (dec_pc),
    .is_jal    (sd_jal),
    .is_branch (sd_br),
    .backward  (sd_back),
    .target    (sd_target)
  );

  // fetch-stage redirect (target-buffer mode)
  logic lk_hit;
  assign lk_hit            = lk_valid && (lk_tag == fetch_pc);
  assign fetch_pred_valid  = USE_TB && lk_hit && lk_ctr[1];
  assign fetch_pred_target = fetch_pred_valid ? lk_tgt : '0;

  // decode-stage hint (counter-table mode)
  logic br_lean;
  assign br_lean         = lk_valid ? lk_ctr[1] : sd_back;
  assign dec_pred_taken  = !USE_TB && dec_valid && (sd_jal || (sd_br && br_lean));
  assign dec_pred_target = dec_pred_taken ? sd_target : '0;

  // no report, no change to the set of live slots
  assert_idle_no_alloc_R4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !upd_valid |=> $stable(i_store.valid_q));

  if (USE_TB) begin : g_tb_chk
    assert_install_tag_R4: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (upd_valid && upd_taken && upd_mispredict) |=>
        (i_store.valid_q[$past(upd_idx)] && (i_store.tag_q[$past(upd_idx)] == $past(upd_pc))));
  end else begin : g_ct_chk
    assert_jal_taken_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (dec_valid && (dec_instr[6:0] == OPC_JAL)) |-> (dec_pred_taken && !fetch_pred_valid));
  end

endmodule

// File: tb/test_fetch_target_predictor.sv
`timescale 1ns/1ps
module test_fetch_target_predictor;

  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // target-buffer instance
  logic [AW-1:0] m_fpc, m_ftgt, m_dpc, m_dtgt, m_upc, m_utgt;
  logic          m_fv, m_dv, m_dtk, m_uv, m_utk, m_umis;
  logic [31:0]   m_dins;

  fetch_target_predictor #(.ADDR_W(AW), .TBL_LOG2(4), .USE_TB(1'b1)) i_fetch_target_predictor (
    .clk(clk), .rst_n(rst_n), .fetch_pc(m_fpc), .fetch_pred_valid(m_fv),
    .fetch_pred_target(m_ftgt), .dec_valid(m_dv), .dec_pc(m_dpc), .dec_instr(m_dins),
    .dec_pred_taken(m_dtk), .dec_pred_target(m_dtgt), .upd_valid(m_uv), .upd_pc(m_upc),
    .upd_target(m_utgt), .upd_taken(m_utk), .upd_mispredict(m_umis));

  // counter-table instance
  logic [AW-1:0] s_fpc, s_ftgt, s_dpc, s_dtgt, s_upc, s_utgt;
  logic          s_fv, s_dv, s_dtk, s_uv, s_utk, s_umis;
  logic [31:0]   s_dins;

  fetch_target_predictor #(.ADDR_W(AW), .TBL_LOG2(4), .USE_TB(1'b0)) i_fetch_target_predictor_st (
    .clk(clk), .rst_n(rst_n), .fetch_pc(s_fpc), .fetch_pred_valid(s_fv),
    .fetch_pred_target(s_ftgt), .dec_valid(s_dv), .dec_pc(s_dpc), .dec_instr(s_dins),
    .dec_pred_taken(s_dtk), .dec_pred_target(s_dtgt), .upd_valid(s_uv), .upd_pc(s_upc),
    .upd_target(s_utgt), .upd_taken(s_utk), .upd_mispredict(s_umis));

  localparam logic [AW-1:0] PA = 32'h0000_1000, PB = 32'h0000_2000;
  localparam logic [AW-1:0] PC = 32'h0000_1004, PD = 32'h0000_1008;
  localparam logic [AW-1:0] T1 = 32'h0000_0800, T2 = 32'h0000_3300, T3 = 32'h0000_4440;
  localparam logic [AW-1:0] T4 = 32'h0000_5550, T5 = 32'h0000_6660, T9 = 32'h0000_9990;

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_jal(input int off);
    logic [20:0] im = 21'(off);
    return {im[20], im[10:1], im[11], im[19:12], 5'd1, 7'b1101111};
  endfunction

  function automatic logic [31:0] enc_br(input int off);
    logic [12:0] im = 13'(off);
    return {im[12], im[10:5], 5'd2, 5'd3, 3'b000, im[4:1], im[11], 7'b1100011};
  endfunction

  // report on the target-buffer instance; returns at a falling edge
  task automatic m_upd(input logic [AW-1:0] pc, input logic [AW-1:0] tgt, input bit tk, input bit mis);
    m_uv = 1'b1; m_upc = pc; m_utgt = tgt; m_utk = tk; m_umis = mis;
    @(negedge clk);
    m_uv = 1'b0;
  endtask

  task automatic s_upd(input logic [AW-1:0] pc, input bit tk, input bit mis);
    s_uv = 1'b1; s_upc = pc; s_utgt = T9; s_utk = tk; s_umis = mis;
    @(negedge clk);
    s_uv = 1'b0;
  endtask

  task automatic m_look(input logic [AW-1:0] pc, input bit ev, input logic [AW-1:0] et, input string req);
    m_fpc = pc;
    #1;
    chk(m_fv == ev, req, AW'(m_fv), AW'(ev));
    chk(m_ftgt == et, req, m_ftgt, et);
  endtask

  task automatic s_dec(input logic [AW-1:0] pc, input logic [31:0] ins, input bit ev,
                       input logic [AW-1:0] et, input string req);
    s_dv = 1'b1; s_dpc = pc; s_dins = ins;
    #1;
    chk(s_dtk == ev, req, AW'(s_dtk), AW'(ev));
    chk(s_dtgt == et, req, s_dtgt, et);
  endtask

  task automatic t_reset;
    m_look(PA, 1'b0, '0, "R1");
    m_look(PC, 1'b0, '0, "R1");
    m_dv = 1'b1; m_dpc = 32'h400; m_dins = enc_jal(256);
    #1;
    chk(m_dtk == 1'b0, "R11", AW'(m_dtk), '0);
    m_dv = 1'b0;
  endtask

  task automatic t_alloc;
    m_upd(PA, T1, 1'b1, 1'b0);
    m_look(PA, 1'b0, '0, "R4 taken without mispredict");
    m_upd(PA, T1, 1'b0, 1'b1);
    m_look(PA, 1'b0, '0, "R4 not taken");
    m_upd(PA, T1, 1'b1, 1'b1);
    m_look(PA, 1'b1, T1, "R3 R4 install");
  endtask

  task automatic t_alias;
    m_look(PB, 1'b0, '0, "R2 alias");
    m_upd(PB, T2, 1'b1, 1'b0);
    m_look(PA, 1'b1, T1, "R2 alias kept");
    m_upd(PB, T2, 1'b1, 1'b1);
    m_look(PB, 1'b1, T2, "R2 replace");
    m_look(PA, 1'b0, '0, "R2 evicted");
  endtask

  task automatic t_counter;
    m_upd(PC, T3, 1'b1, 1'b1);            // 2
    m_upd(PC, T9, 1'b0, 1'b1);            // 1
    m_look(PC, 1'b0, '0, "R5 down to 1");
    m_upd(PC, T3, 1'b1, 1'b1);            // 2
    m_look(PC, 1'b1, T3, "R5 up to 2");
    for (int i = 0; i < 3; i++) m_upd(PC, T3, 1'b1, 1'b0);  // 3
    m_upd(PC, T9, 1'b0, 1'b0);            // 2
    m_look(PC, 1'b1, T3, "R5 upper saturation");
    m_upd(PC, T9, 1'b0, 1'b0);            // 1
    m_look(PC, 1'b0, '0, "R5 step down");
    for (int i = 0; i < 3; i++) m_upd(PC, T9, 1'b0, 1'b0);  // 0
    m_upd(PC, T3, 1'b1, 1'b0);            // 1
    m_look(PC, 1'b0, '0, "R5 lower saturation");
    m_upd(PC, T3, 1'b1, 1'b0);            // 2
    m_look(PC, 1'b1, T3, "R6 not-taken keeps target");
  endtask

  task automatic t_retarget;
    m_upd(PC, T4, 1'b1, 1'b0);            // 3, new target
    m_look(PC, 1'b1, T4, "R6 retarget");
    m_upd(PC, T9, 1'b0, 1'b0);            // 2
  endtask

  task automatic t_collision;
    m_fpc = PC; m_uv = 1'b1; m_upc = PC; m_utgt = T9; m_utk = 1'b0; m_umis = 1'b1;
    #1;
    chk(m_fv == 1'b1, "R7 old state same cycle", AW'(m_fv), 1);
    chk(m_ftgt == T4, "R7 old target", m_ftgt, T4);
    @(negedge clk); m_uv = 1'b0;
    m_look(PC, 1'b0, '0, "R7 new state next cycle");
    m_fpc = PD; m_uv = 1'b1; m_upc = PD; m_utgt = T5; m_utk = 1'b1; m_umis = 1'b1;
    #1;
    chk(m_fv == 1'b0, "R7 install not seen same cycle", AW'(m_fv), 0);
    @(negedge clk); m_uv = 1'b0;
    m_look(PD, 1'b1, T5, "R7 install seen next cycle");
  endtask

  task automatic t_static;
    s_fpc = 32'h400;
    #1;
    chk(s_fv == 1'b0, "R8 fetch quiet", AW'(s_fv), 0);
    s_dec(32'h400, enc_jal(256), 1'b1, 32'h500, "R8 jal forward");
    s_dec(32'h440, enc_jal(-8), 1'b1, 32'h438, "R8 jal backward");
    s_dec(32'h440, enc_br(-16), 1'b1, 32'h430, "R9 backward branch");
    s_dec(32'h400, enc_br(32), 1'b0, '0, "R9 forward branch");
    s_dec(32'h400, 32'h0050_0093, 1'b0, '0, "R9 other opcode");
  endtask

  task automatic t_history;
    s_upd(32'h48, 1'b1, 1'b0);
    s_dec(32'h48, enc_br(32), 1'b1, 32'h68, "R10 history taken");
    s_fpc = 32'h48;
    #1;
    chk(s_fv == 1'b0, "R8 fetch quiet after update", AW'(s_fv), 0);
    s_upd(32'h48, 1'b0, 1'b1);
    s_dec(32'h48, enc_br(32), 1'b0, '0, "R10 history not taken");
    s_dec(32'h88, enc_br(-16), 1'b0, '0, "R10 history overrides sign");
    s_dv = 1'b0;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    m_fpc = '0; m_dv = 1'b0; m_dpc = '0; m_dins = '0;
    m_uv = 1'b0; m_upc = '0; m_utgt = '0; m_utk = 1'b0; m_umis = 1'b0;
    s_fpc = '0; s_dv = 1'b0; s_dpc = '0; s_dins = '0;
    s_uv = 1'b0; s_upc = '0; s_utgt = '0; s_utk = 1'b0; s_umis = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_alloc;
    t_alias;
    t_counter;
    t_retarget;
    t_collision;
    t_static;
    t_history;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule